// File: doc/BRIEF.md
# Sprite Overlay Pixel Pipeline

This block lays a set of hardware sprites over a framebuffer pixel stream as the display is scanned. Each sprite has a box on the screen (a corner position and a width and height) and a base address into a small on-chip byte memory that holds sprite pixel art. For every pixel, every sprite's box is compared against the scan position at the same time. The highest-numbered sprite whose box covers the pixel wins. Its byte is fetched, and it replaces the framebuffer byte unless the byte is zero.

The work is split into four pipeline stages that advance on a pixel enable. The stages are: box test, address arithmetic, memory read, and final selection. The scan coordinates supplied by the display timing must run four pixel steps ahead of the pixel being shown. The framebuffer byte is taken at the last stage.

Sprite attributes and sprite memory are written through a strobe-per-command interface that shares an index bus, two coordinate buses and an address bus. Writes may happen at any time, including in the middle of a frame.

Top module: `sprite_overlay`

## Requirements
- R1: While reset is asserted and after it is released, pix_out is 0 until the first enabled pixel step. Reset clears every sprite's position, size and base to zero, so no sprite is visible until it is written.
- R2: Scan coordinates sampled at an enabled clock edge k produce their pixel on pix_out at enabled edge k+3. The framebuffer byte used is the fb_pix value present at edge k+3.
- R3: A sprite covers the scan position (sx, sy) when pos_x <= sx < pos_x + width and pos_y <= sy < pos_y + height. The comparison uses unsigned 11-bit coordinates, and the right and bottom edges are computed with one extra bit so that they never wrap.
- R4: A sprite whose width or height is zero never covers any pixel.
- R5: When no sprite covers the pixel, pix_out equals the framebuffer byte.
- R6: For the winning sprite, the memory word read is (base + width*ly + lx) mod 65536, reduced to its low MEM_AW bits. Here lx = sx - pos_x and ly = sy - pos_y. A nonzero byte read there is shown.
- R7: A wr_fill strobe stores wr_x[7:0] at wr_addr when wr_addr < 2**MEM_AW. A fill to a higher address changes nothing.
- R8: When several sprites cover a pixel, only the highest-index one is used. If its byte is zero, the framebuffer byte is shown, and no lower sprite shows through.
- R9: While pix_en is low, no pipeline stage advances and pix_out holds its value, whatever the scan and framebuffer inputs do.
- R10: wr_loc loads pos_x, pos_y from wr_x, wr_y. wr_size loads width, height from wr_x[7:0], wr_y[7:0]. wr_base loads base from wr_addr. Each applies to sprite wr_idx from the next pixel evaluated onward, and a write whose wr_idx >= NUM_SPR is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pix_en | input | 1 | Pixel step enable; all stages advance when high |
| scan_x | input | 11 | Horizontal scan position, four pixel steps ahead of display |
| scan_y | input | 11 | Vertical scan position |
| fb_pix | input | 8 | Framebuffer byte for the pixel leaving the pipeline |
| wr_loc | input | 1 | Write sprite position strobe |
| wr_size | input | 1 | Write sprite width/height strobe |
| wr_base | input | 1 | Write sprite memory base strobe |
| wr_fill | input | 1 | Write sprite memory byte strobe |
| wr_idx | input | 8 | Sprite index for attribute writes |
| wr_x | input | 11 | X position, width (low 8 bits) or fill byte (low 8 bits) |
| wr_y | input | 11 | Y position or height (low 8 bits) |
| wr_addr | input | 16 | Sprite base or fill address |
| pix_out | output | 8 | Final pixel byte |

## Verification
The assertions take for granted that reset is applied before the first clock and that the strobes and pix_en are always driven to known levels. They also assume that sprite memory is read only after it has been written, so stage-three data is never unknown when a hit selects it. The stimulus writes every memory word before any sprite gets a nonzero size, and changes inputs only on the falling clock edge. Attribute writes are always placed between pixel streams, so each stream sees one fixed set of sprites.

// File: rtl/sprite_ovl_pkg.sv
package sprite_ovl_pkg;
   localparam int COORD_W = 11;
   localparam int DIM_W   = 8;
   localparam int OFFS_W  = 16;
   localparam int PIX_W   = 8;

   typedef logic [COORD_W-1:0] coord_t;
   typedef logic [DIM_W-1:0]   dim_t;
   typedef logic [OFFS_W-1:0]  offs_t;
   typedef logic [PIX_W-1:0]   pix_t;

   typedef struct packed {
      coord_t pos_x;
      coord_t pos_y;
      dim_t   wid;
      dim_t   hgt;
      offs_t  base;
   } spr_attr_t;
endpackage

// File: rtl/sprite_attr_file.sv
module sprite_attr_file
   import sprite_ovl_pkg::*;
#(
   parameter int NUM_SPR = 40,
   parameter int IDX_W   = 8
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     wr_loc,
   input  logic                     wr_size,
   input  logic                     wr_base,
   input  logic [IDX_W-1:0]         wr_idx,
   input  coord_t                   wr_x,
   input  coord_t                   wr_y,
   input  offs_t                    wr_addr,
   output spr_attr_t [NUM_SPR-1:0]  attr
);
   localparam int CMP_W = IDX_W + 1;

   logic idx_ok;
   assign idx_ok = {1'b0, wr_idx} < CMP_W'(NUM_SPR);

   for (genvar g = 0; g < NUM_SPR; g++) begin : g_slot
      logic sel;
      assign sel = idx_ok && (wr_idx == IDX_W'(g));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            attr[g] <= '0;
         end else if (sel) begin
            if (wr_loc) begin
               attr[g].pos_x <= wr_x;
               attr[g].pos_y <= wr_y;
            end
            if (wr_size) begin
               attr[g].wid <= wr_x[DIM_W-1:0];
               attr[g].hgt <= wr_y[DIM_W-1:0];
            end
            if (wr_base) begin
               attr[g].base <= wr_addr;
            end
         end
      end
   end

   AST_BAD_IDX_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
      ((wr_loc || wr_size || wr_base) && !idx_ok) |=> $stable(attr)); // R10
endmodule

// File: rtl/sprite_hit_stage.sv
module sprite_hit_stage
   import sprite_ovl_pkg::*;
#(
   parameter int NUM_SPR = 40,
   parameter int IDX_W   = 8
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     adv,
   input  coord_t                   scan_x,
   input  coord_t                   scan_y,
   input  spr_attr_t [NUM_SPR-1:0]  attr,
   output logic                     hit_q,
   output logic [IDX_W-1:0]         idx_q,
   output dim_t                     lx_q,
   output dim_t                     ly_q
);
   localparam int EXT_W = COORD_W + 1;

   logic [NUM_SPR-1:0] in_box;
   dim_t               rel_x [NUM_SPR];
   dim_t               rel_y [NUM_SPR];

   for (genvar g = 0; g < NUM_SPR; g++) begin : g_cmp
      logic [EXT_W-1:0] end_x;
      logic [EXT_W-1:0] end_y;
      logic             in_x;
      logic             in_y;

      assign end_x    = {1'b0, attr[g].pos_x} + EXT_W'(attr[g].wid);
      assign end_y    = {1'b0, attr[g].pos_y} + EXT_W'(attr[g].hgt);
      assign in_x     = (scan_x >= attr[g].pos_x) && ({1'b0, scan_x} < end_x);
      assign in_y     = (scan_y >= attr[g].pos_y) && ({1'b0, scan_y} < end_y);
      assign in_box[g] = in_x && in_y;
      assign rel_x[g] = DIM_W'(scan_x - attr[g].pos_x);
      assign rel_y[g] = DIM_W'(scan_y - attr[g].pos_y);

      AST_ZERO_DIM_NO_HIT: assert property (@(posedge clk) disable iff (!rst_n)
         (adv && (attr[g].wid == '0 || attr[g].hgt == '0))
            |=> !(hit_q && idx_q == IDX_W'(g))); // R4
   end

   logic             hit_d;
   logic [IDX_W-1:0] idx_d;
   dim_t             lx_d;
   dim_t             ly_d;

   always_comb begin
      hit_d = 1'b0;
      idx_d = '0;
      lx_d  = '0;
      ly_d  = '0;
      for (int i = 0; i < NUM_SPR; i++) begin
         if (in_box[i]) begin
            hit_d = 1'b1;
            idx_d = IDX_W'(i);
            lx_d  = rel_x[i];
            ly_d  = rel_y[i];
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hit_q <= 1'b0;
         idx_q <= '0;
         lx_q  <= '0;
         ly_q  <= '0;
      end else if (adv) begin
         hit_q <= hit_d;
         idx_q <= idx_d;
         lx_q  <= lx_d;
         ly_q  <= ly_d;
      end
   end
endmodule

// File: rtl/sprite_addr_stage.sv
module sprite_addr_stage
   import sprite_ovl_pkg::*;
#(
   parameter int NUM_SPR = 40,
   parameter int IDX_W   = 8,
   parameter int MEM_AW  = 11
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     adv,
   input  logic                     hit_in,
   input  logic [IDX_W-1:0]         idx_in,
   input  dim_t                     lx_in,
   input  dim_t                     ly_in,
   input  spr_attr_t [NUM_SPR-1:0]  attr,
   output logic                     hit_q,
   output logic [MEM_AW-1:0]        addr_q
);
   localparam int PROD_W = 2 * DIM_W;

   dim_t                sel_w;
   offs_t               sel_base;
   logic [PROD_W-1:0]   prod;
   logic [MEM_AW-1:0]   addr_d;

   always_comb begin
      sel_w    = '0;
      sel_base = '0;
      for (int i = 0; i < NUM_SPR; i++) begin
         if (idx_in == IDX_W'(i)) begin
            sel_w    = attr[i].wid;
            sel_base = attr[i].base;
         end
      end
   end

   assign prod   = sel_w * ly_in;
   assign addr_d = MEM_AW'(sel_base) + MEM_AW'(prod) + MEM_AW'(lx_in);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hit_q  <= 1'b0;
         addr_q <= '0;
      end else if (adv) begin
         hit_q  <= hit_in;
         addr_q <= addr_d;
      end
   end
endmodule

// File: rtl/sprite_pix_mem.sv
module sprite_pix_mem
   import sprite_ovl_pkg::*;
#(
   parameter int MEM_AW = 11
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  offs_t             wr_addr,
   input  pix_t              wr_data,
   input  logic              rd_en,
   input  logic [MEM_AW-1:0] rd_addr,
   output pix_t              rd_data
);
   localparam int DEPTH = 1 << MEM_AW;

   pix_t mem [DEPTH];
   logic wr_ok;

   if (MEM_AW < OFFS_W) begin : g_part
      assign wr_ok = (wr_addr[OFFS_W-1:MEM_AW] == '0);
   end else begin : g_full
      assign wr_ok = 1'b1;
   end

   always_ff @(posedge clk) begin
      if (wr_en && wr_ok) begin
         mem[wr_addr[MEM_AW-1:0]] <= wr_data;
      end
      if (rd_en) begin
         rd_data <= mem[rd_addr];
      end
   end

   AST_FILL_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_ok) |=> mem[$past(wr_addr[MEM_AW-1:0])] == $past(wr_data)); // R7
endmodule

// File: rtl/sprite_overlay.sv
module sprite_overlay
   import sprite_ovl_pkg::*;
#(
   parameter int NUM_SPR = 40,
   parameter int IDX_W   = 8,
   parameter int MEM_AW  = 11
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              pix_en,
   input  logic [10:0]       scan_x,
   input  logic [10:0]       scan_y,
   input  logic [7:0]        fb_pix,
   input  logic              wr_loc,
   input  logic              wr_size,
   input  logic              wr_base,
   input  logic              wr_fill,
   input  logic [IDX_W-1:0]  wr_idx,
   input  logic [10:0]       wr_x,
   input  logic [10:0]       wr_y,
   input  logic [15:0]       wr_addr,
   output logic [7:0]        pix_out
);
   if (NUM_SPR < 1 || NUM_SPR > (1 << IDX_W)) begin : g_bad_count
      $error("sprite_overlay: NUM_SPR must fit in IDX_W bits");
   end
   if (MEM_AW < 1 || MEM_AW > OFFS_W) begin : g_bad_depth
      $error("sprite_overlay: MEM_AW must be between 1 and OFFS_W");
   end

   spr_attr_t [NUM_SPR-1:0] attr;
   logic                    s1_hit;
   logic [IDX_W-1:0]        s1_idx;
   dim_t                    s1_lx;
   dim_t                    s1_ly;
   logic                    s2_hit;
   logic [MEM_AW-1:0]       s2_addr;
   logic                    s3_hit;
   pix_t                    s3_data;

   sprite_attr_file #(.NUM_SPR(NUM_SPR), .IDX_W(IDX_W)) u_attr (
      .clk(clk), .rst_n(rst_n),
      .wr_loc(wr_loc), .wr_size(wr_size), .wr_base(wr_base),
      .wr_idx(wr_idx), .wr_x(wr_x), .wr_y(wr_y), .wr_addr(wr_addr),
      .attr(attr)
   );

   sprite_hit_stage #(.NUM_SPR(NUM_SPR), .IDX_W(IDX_W)) u_hit (
      .clk(clk), .rst_n(rst_n), .adv(pix_en),
      .scan_x(scan_x), .scan_y(scan_y), .attr(attr),
      .hit_q(s1_hit), .idx_q(s1_idx), .lx_q(s1_lx), .ly_q(s1_ly)
   );

   sprite_addr_stage #(.NUM_SPR(NUM_SPR), .IDX_W(IDX_W), .MEM_AW(MEM_AW)) u_addr (
      .clk(clk), .rst_n(rst_n), .adv(pix_en),
      .hit_in(s1_hit), .idx_in(s1_idx), .lx_in(s1_lx), .ly_in(s1_ly),
      .attr(attr), .hit_q(s2_hit), .addr_q(s2_addr)
   );

   sprite_pix_mem #(.MEM_AW(MEM_AW)) u_mem (
      .clk(clk), .rst_n(rst_n),
      .wr_en(wr_fill), .wr_addr(wr_addr), .wr_data(wr_x[PIX_W-1:0]),
      .rd_en(pix_en), .rd_addr(s2_addr), .rd_data(s3_data)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         s3_hit <= 1'b0;
      end else if (pix_en) begin
         s3_hit <= s2_hit;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pix_out <= '0;
      end else if (pix_en) begin
         pix_out <= (s3_hit && s3_data != '0) ? s3_data : fb_pix;
      end
   end

   AST_HOLD_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !pix_en |=> $stable(pix_out)); // R9
   AST_MISS_SHOWS_FB: assert property (@(posedge clk) disable iff (!rst_n)
      (pix_en && !s3_hit) |=> pix_out == $past(fb_pix)); // R5
endmodule

// File: tb/sprite_overlay_test.sv
module sprite_overlay_test;
   localparam int NS    = 40;
   localparam int IW    = 8;
   localparam int AW    = 11;
   localparam int DEPTH = 1 << AW;

   logic          clk = 1'b0;
   logic          rst_n;
   logic          pix_en;
   logic [10:0]   scan_x, scan_y;
   logic [7:0]    fb_pix;
   logic          wr_loc, wr_size, wr_base, wr_fill;
   logic [IW-1:0] wr_idx;
   logic [10:0]   wr_x, wr_y;
   logic [15:0]   wr_addr;
   logic [7:0]    pix_out;

   always #5 clk = ~clk;

   sprite_overlay #(.NUM_SPR(NS), .IDX_W(IW), .MEM_AW(AW)) uut (
      .clk(clk), .rst_n(rst_n), .pix_en(pix_en),
      .scan_x(scan_x), .scan_y(scan_y), .fb_pix(fb_pix),
      .wr_loc(wr_loc), .wr_size(wr_size), .wr_base(wr_base), .wr_fill(wr_fill),
      .wr_idx(wr_idx), .wr_x(wr_x), .wr_y(wr_y), .wr_addr(wr_addr),
      .pix_out(pix_out)
   );

   int n_chk = 0;
   int n_fail = 0;
   int bx [NS];
   int by [NS];
   int bw [NS];
   int bh [NS];
   int boff [NS];
   logic [7:0] bmem [DEPTH];

   task automatic chk(string req, string what, logic [7:0] act, logic [7:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   function automatic logic [7:0] model(int sx, int sy, logic [7:0] fb);
      int win = -1;
      int lx = 0;
      int ly = 0;
      int a;
      for (int i = 0; i < NS; i++) begin
         if (bw[i] != 0 && bh[i] != 0 && sx >= bx[i] && sx < bx[i] + bw[i] &&
             sy >= by[i] && sy < by[i] + bh[i]) begin
            win = i; lx = sx - bx[i]; ly = sy - by[i];
         end
      end
      if (win < 0) return fb;
      a = ((boff[win] + bw[win] * ly + lx) % 65536) % DEPTH;
      return (bmem[a] != 8'h00) ? bmem[a] : fb;
   endfunction

   task automatic cmd(bit l, bit s, bit b, bit f, int idx, int x, int y, int a);
      @(negedge clk);
      wr_loc = l; wr_size = s; wr_base = b; wr_fill = f;
      wr_idx = IW'(idx); wr_x = 11'(x); wr_y = 11'(y); wr_addr = 16'(a);
      @(negedge clk);
      wr_loc = 0; wr_size = 0; wr_base = 0; wr_fill = 0;
   endtask

   task automatic set_loc(int i, int x, int y);
      cmd(1, 0, 0, 0, i, x, y, 0);
      if (i < NS) begin bx[i] = x; by[i] = y; end
   endtask
   task automatic set_size(int i, int w, int h);
      cmd(0, 1, 0, 0, i, w, h, 0);
      if (i < NS) begin bw[i] = w; bh[i] = h; end
   endtask
   task automatic set_base(int i, int a);
      cmd(0, 0, 1, 0, i, 0, 0, a);
      if (i < NS) boff[i] = a;
   endtask
   task automatic fill(int a, int v);
      cmd(0, 0, 0, 1, 0, v, 0, a);
      if (a < DEPTH) bmem[a] = 8'(v);
   endtask

   // Pixel stream: coordinates advance by (dx,dy); gap inserts an idle cycle per pixel.
   task automatic stream(string req, int x0, int y0, int len, int dx, int dy, bit gap);
      int qx [64];
      int qy [64];
      logic [7:0] qf [64];
      for (int j = 0; j < len + 4; j++) begin
         int k = (j < len) ? j : len - 1;
         qx[j] = x0 + dx * k;
         qy[j] = y0 + dy * k;
         qf[j] = 8'((j * 53 + 7) ^ (x0 + y0));
      end
      for (int j = 0; j < len + 4; j++) begin
         @(negedge clk);
         if (j >= 4) chk(req, $sformatf("x=%0d y=%0d", qx[j-4], qy[j-4]), pix_out,
                         model(qx[j-4], qy[j-4], qf[j-1]));
         pix_en = 1; scan_x = 11'(qx[j]); scan_y = 11'(qy[j]); fb_pix = qf[j];
         if (gap) begin
            @(negedge clk);
            if (j >= 3) chk("R9", $sformatf("idle x=%0d", qx[j-3]), pix_out,
                            model(qx[j-3], qy[j-3], qf[j]));
            pix_en = 0; scan_x = 11'(j * 97 + 3); scan_y = 11'(j * 41 + 9);
            fb_pix = 8'(j * 29 + 1);
         end
      end
      @(negedge clk);
      pix_en = 0;
   endtask

   task automatic t_reset();
      rst_n = 0;
      repeat (3) @(negedge clk);
      chk("R1", "in reset", pix_out, 8'h00);
      rst_n = 1;
      repeat (3) @(negedge clk);
      chk("R1", "after reset idle", pix_out, 8'h00);
      stream("R1", 10, 10, 8, 1, 0, 0);
      stream("R5", 600, 470, 8, 3, 0, 0);
   endtask

   task automatic t_fill();
      for (int a = 0; a < DEPTH; a++) fill(a, (a % 7 == 0) ? 0 : ((a * 37 + 11) & 255));
      fill(DEPTH + 16'h41, 8'hAA);
      fill(16'h42, 8'h5A);
   endtask

   task automatic t_single();
      set_loc(0, 100, 50); set_size(0, 12, 6); set_base(0, 16'h40);
      stream("R7", 95, 50, 20, 1, 0, 0);
      stream("R6", 95, 55, 20, 1, 0, 0);
      stream("R3", 95, 56, 20, 1, 0, 0);
      stream("R2", 105, 47, 12, 0, 1, 0);
   endtask

   task automatic t_edge();
      set_loc(9, 2040, 400); set_size(9, 20, 4); set_base(9, 16'hFFF0);
      stream("R3", 2035, 401, 13, 1, 0, 0);
   endtask

   task automatic t_priority();
      set_loc(3, 500, 300); set_size(3, 16, 16); set_base(3, 16'h100);
      set_loc(5, 508, 300); set_size(5, 16, 16); set_base(5, 0);
      stream("R8", 495, 305, 35, 1, 0, 0);
   endtask

   task automatic t_zero_dim();
      set_loc(2, 298, 198); set_size(2, 20, 20); set_base(2, 300);
      set_loc(6, 300, 200); set_size(6, 0, 10); set_base(6, 16'h20);
      set_loc(7, 300, 200); set_size(7, 10, 0); set_base(7, 16'h30);
      stream("R4", 295, 202, 20, 1, 0, 0);
   endtask

   task automatic t_bad_index();
      set_loc(8, 800, 150); set_size(8, 10, 10); set_base(8, 16'h300);
      set_loc(72, 100, 150);
      set_size(NS, 0, 0);
      set_base(255, 16'h10);
      stream("R10", 795, 155, 18, 1, 0, 0);
      stream("R10", 98, 152, 14, 1, 0, 0);
   endtask

   task automatic t_gap();
      stream("R9", 97, 52, 16, 1, 0, 1);
   endtask

   task automatic t_move();
      set_loc(0, 700, 100);
      stream("R10", 98, 52, 14, 1, 0, 0);
      stream("R10", 698, 102, 16, 1, 0, 0);
   endtask

   initial begin
      pix_en = 0; scan_x = 0; scan_y = 0; fb_pix = 0;
      wr_loc = 0; wr_size = 0; wr_base = 0; wr_fill = 0;
      wr_idx = 0; wr_x = 0; wr_y = 0; wr_addr = 0;
      for (int i = 0; i < NS; i++) begin
         bx[i] = 0; by[i] = 0; bw[i] = 0; bh[i] = 0; boff[i] = 0;
      end
      t_reset();
      t_fill();
      t_single();
      t_edge();
      t_priority();
      t_zero_dim();
      t_bad_index();
      t_gap();
      t_move();
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
   end
endmodule